// File: doc/BRIEF.md
# Four-Lane Byte/Word Data Buffer

This block is a data buffer built from four byte-wide FIFO lanes of equal depth that sit side by side. A producer may push either a full word, which places one byte in each lane, or a single byte, which goes into lane 0 only. A consumer may likewise pop either a word, taking the head byte of every lane at once, or a single byte from the head of lane 0. Seen through the word ports the buffer holds `LANES*DEPTH` bytes. Seen through the byte ports it holds only `DEPTH` bytes.

All four access ports are valid/ready streams. A push or pop happens on a rising clock edge where both valid and ready are high. The write ports take back-pressure through their ready outputs: a producer holds its data and valid until ready returns. The read ports offer data through their valid outputs, and the consumer accepts it with ready. At most one push and one pop occur per cycle. On each side the word port has priority over the byte port.

A six-bit status vector reports occupancy conditions and illegal accesses. Every bit is sticky and is cleared by a write-one pulse on the matching bit of the clear input.

Top module: `quad_lane_fifo`

## Requirements
- R1: While `rst_n` is low, all lanes are empty, `flags` is 0, both write readies are 1, and both read valids are 0.
- R2: `wr_word_ready` is 1 exactly when no lane is full. An accepted word puts data bits [8k+7:8k] into lane k, for k = 0..3.
- R3: An accepted byte goes into lane 0 only. `wr_byte_ready` is 1 when lane 0 is not full and `wr_word_valid` is 0, so a word push offered in the same cycle takes precedence.
- R4: `rd_word_valid` is 1 exactly when every lane holds at least one byte. `rd_word_data` bits [8k+7:8k] are the head of lane k, and an accepted word pops every lane. Each lane keeps first-in first-out order.
- R5: `rd_byte_valid` is 1 when lane 0 is not empty and `rd_word_ready` is 0. `rd_byte_data` is the head of lane 0, and an accepted byte pops lane 0 only.
- R6: With the default parameters the buffer takes 16 words (64 bytes) through the word port, or 16 bytes through the byte port, before the matching ready drops.
- R7: A push and a pop accepted in the same cycle both take effect, and the occupancy is unchanged.
- R8: The condition bits of `flags` are: bit 0, some lane is full; bit 1, some lane holds at least DEPTH/2 bytes; bit 2, every lane is empty; bit 3, a word is available; bit 4, lane 0 holds a byte; bit 5, an illegal access occurred. Each bit is set at the clock edge after its condition is seen.
- R9: A set flag bit stays set until a cycle in which its `flag_clr` bit is 1. If the condition still holds in that cycle, the bit stays set.
- R10: Bit 5 is set by any of these four attempts: offering a word while some lane is full, offering a byte while lane 0 is full, raising `rd_word_ready` while some lane is empty, or raising `rd_byte_ready` while lane 0 is empty. No data moves on such an attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_word_valid | input | 1 | Word push offered |
| wr_word_ready | output | 1 | Word push can be taken |
| wr_word_data | input | LANES*BW | Word to push, byte k for lane k |
| wr_byte_valid | input | 1 | Byte push offered |
| wr_byte_ready | output | 1 | Byte push can be taken |
| wr_byte_data | input | BW | Byte to push into lane 0 |
| rd_word_valid | output | 1 | Word available to pop |
| rd_word_ready | input | 1 | Consumer takes a word |
| rd_word_data | output | LANES*BW | Heads of all lanes |
| rd_byte_valid | output | 1 | Byte available to pop |
| rd_byte_ready | input | 1 | Consumer takes a byte |
| rd_byte_data | output | BW | Head of lane 0 |
| flag_clr | input | 6 | Write-one clear pulse per flag bit |
| flags | output | 6 | Sticky status bits |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a word push and a word pop. To provoke it, the buffer is first filled and then one word is drained, and the bench then raises both handshakes in one cycle. The bench judges the result by checking that both handshakes complete, that the write stays ready, and that the popped data keeps its order.

The second pair is a flag clear and the condition that sets that flag. The bench pulses a clear on every bit while the buffer is full and checks that the full, half, word and byte bits come back at once. In the same step it checks that the illegal-access and empty bits drop. A scoreboard keeps one queue per lane and compares every popped word and byte against it.

// File: rtl/quad_lane_fifo_pkg.sv
package quad_lane_fifo_pkg;
  localparam int FLAG_W   = 6;
  localparam int FL_FULL  = 0;
  localparam int FL_HALF  = 1;
  localparam int FL_EMPTY = 2;
  localparam int FL_WORD  = 3;
  localparam int FL_BYTE  = 4;
  localparam int FL_ERR   = 5;
endpackage

// File: rtl/qlf_lane.sv
// One byte lane: circular storage with read/write pointers and an occupancy count.
module qlf_lane #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = store[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/qlf_sticky.sv
// Sticky status register: set by condition, cleared by write-one unless the condition persists.
module qlf_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic [W-1:0] clr,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n) state <= '0;
    else        state <= cond | (state & ~clr);
  end
endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo
  import quad_lane_fifo_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int BW    = 8,
  localparam int WW   = LANES * BW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word_valid,
  output logic              wr_word_ready,
  input  logic [WW-1:0]     wr_word_data,
  input  logic              wr_byte_valid,
  output logic              wr_byte_ready,
  input  logic [BW-1:0]     wr_byte_data,
  output logic              rd_word_valid,
  input  logic              rd_word_ready,
  output logic [WW-1:0]     rd_word_data,
  output logic              rd_byte_valid,
  input  logic              rd_byte_ready,
  output logic [BW-1:0]     rd_byte_data,
  input  logic [FLAG_W-1:0] flag_clr,
  output logic [FLAG_W-1:0] flags
);
  logic [LANES-1:0] lane_full, lane_empty, lane_half, lane_push, lane_pop;
  logic [BW-1:0]    lane_head [LANES];
  logic [CW-1:0]    lane_cnt  [LANES];
  logic             word_in_go, byte_in_go, word_out_go, byte_out_go;
  logic             all_room, all_data;
  logic [FLAG_W-1:0] cond;

  assign all_room = ~|lane_full;
  assign all_data = ~|lane_empty;

  // Write-side arbitration: word port first, byte port uses lane 0.
  assign wr_word_ready = all_room;
  assign wr_byte_ready = ~lane_full[0] & ~wr_word_valid;
  assign word_in_go    = wr_word_valid & wr_word_ready;
  assign byte_in_go    = wr_byte_valid & wr_byte_ready;

  // Read-side arbitration: word port first, byte port reads lane 0.
  assign rd_word_valid = all_data;
  assign rd_byte_valid = ~lane_empty[0] & ~rd_word_ready;
  assign word_out_go   = rd_word_valid & rd_word_ready;
  assign byte_out_go   = rd_byte_valid & rd_byte_ready;
  assign rd_byte_data  = lane_head[0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BW-1:0] lane_din;
    if (k == 0) begin : g_first
      assign lane_push[k] = word_in_go | byte_in_go;
      assign lane_pop[k]  = word_out_go | byte_out_go;
      assign lane_din     = word_in_go ? wr_word_data[k*BW +: BW] : wr_byte_data;
    end else begin : g_rest
      assign lane_push[k] = word_in_go;
      assign lane_pop[k]  = word_out_go;
      assign lane_din     = wr_word_data[k*BW +: BW];
    end

    qlf_lane #(.DW(BW), .DEPTH(DEPTH)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lane_push[k]),
      .din   (lane_din),
      .pop   (lane_pop[k]),
      .head  (lane_head[k]),
      .count (lane_cnt[k]),
      .full  (lane_full[k]),
      .empty (lane_empty[k])
    );

    assign lane_half[k] = (lane_cnt[k] >= CW'(DEPTH / 2));
    assign rd_word_data[k*BW +: BW] = lane_head[k];
  end

  always_comb begin
    cond           = '0;
    cond[FL_FULL]  = |lane_full;
    cond[FL_HALF]  = |lane_half;
    cond[FL_EMPTY] = &lane_empty;
    cond[FL_WORD]  = all_data;
    cond[FL_BYTE]  = ~lane_empty[0];
    cond[FL_ERR]   = (wr_word_valid & ~all_room)
                   | (wr_byte_valid & lane_full[0])
                   | (rd_word_ready & ~all_data)
                   | (rd_byte_ready & lane_empty[0]);
  end

  qlf_sticky #(.W(FLAG_W)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (cond),
    .clr   (flag_clr),
    .state (flags)
  );
endmodule

// File: rtl/quad_lane_fifo_chk.sv
module quad_lane_fifo_chk
  import quad_lane_fifo_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int BW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_word_valid,
  input logic              wr_word_ready,
  input logic              wr_byte_valid,
  input logic              wr_byte_ready,
  input logic              rd_word_valid,
  input logic              rd_word_ready,
  input logic              rd_byte_valid,
  input logic              rd_byte_ready,
  input logic [FLAG_W-1:0] flag_clr,
  input logic [FLAG_W-1:0] flags
);
  // Shadow occupancy of lane 0 and lane 1, rebuilt from the port handshakes.
  logic [CW-1:0] occ0, occ1;
  logic ww, wb, rw, rb;
  assign ww = wr_word_valid & wr_word_ready;
  assign wb = wr_byte_valid & wr_byte_ready;
  assign rw = rd_word_valid & rd_word_ready;
  assign rb = rd_byte_valid & rd_byte_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ0 <= '0;
      occ1 <= '0;
    end else begin
      occ0 <= occ0 + CW'(ww | wb) - CW'(rw | rb);
      occ1 <= occ1 + CW'(ww) - CW'(rw);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_ready || wr_byte_ready) |-> (occ0 < CW'(DEPTH)));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word_valid |-> (occ0 != '0 && occ1 != '0));
  // R5
  rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word_ready |-> !rd_byte_valid);
  // R3
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_word_valid |-> !wr_byte_ready);
  // R8
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ0 == CW'(DEPTH)) |=> flags[FL_FULL]);
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_ERR]) |-> $past(flag_clr[FL_ERR]));
endmodule

bind quad_lane_fifo quad_lane_fifo_chk #(.LANES(LANES), .DEPTH(DEPTH), .BW(BW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_word_valid (wr_word_valid),
  .wr_word_ready (wr_word_ready),
  .wr_byte_valid (wr_byte_valid),
  .wr_byte_ready (wr_byte_ready),
  .rd_word_valid (rd_word_valid),
  .rd_word_ready (rd_word_ready),
  .rd_byte_valid (rd_byte_valid),
  .rd_byte_ready (rd_byte_ready),
  .flag_clr      (flag_clr),
  .flags         (flags)
);

// File: tb/quad_lane_fifo_bench.sv
`timescale 1ns/1ps
module quad_lane_fifo_bench;
  localparam int LANES = 4;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_word_valid = 1'b0, wr_byte_valid = 1'b0;
  logic        rd_word_ready = 1'b0, rd_byte_ready = 1'b0;
  logic [31:0] wr_word_data = '0;
  logic [7:0]  wr_byte_data = '0;
  logic [5:0]  flag_clr = '0;
  logic        wr_word_ready, wr_byte_ready, rd_word_valid, rd_byte_valid;
  logic [31:0] rd_word_data;
  logic [7:0]  rd_byte_data;
  logic [5:0]  flags;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  lane_q [LANES][$];
  logic [31:0] exp_q [$];
  logic [31:0] obs_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  quad_lane_fifo u_quad_lane_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_word_valid(wr_word_valid), .wr_word_ready(wr_word_ready), .wr_word_data(wr_word_data),
    .wr_byte_valid(wr_byte_valid), .wr_byte_ready(wr_byte_ready), .wr_byte_data(wr_byte_data),
    .rd_word_valid(rd_word_valid), .rd_word_ready(rd_word_ready), .rd_word_data(rd_word_data),
    .rd_byte_valid(rd_byte_valid), .rd_byte_ready(rd_byte_ready), .rd_byte_data(rd_byte_data),
    .flag_clr(flag_clr), .flags(flags)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare observed read data against the scoreboard expectations.
  always @(negedge clk) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [31:0] o, e;
      string t;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(o == e, t, o, e);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_word(input logic [31:0] d, input bit exp_ok);
    @(negedge clk);
    wr_word_valid = 1'b1; wr_word_data = d;
    #1;
    check(wr_word_ready == exp_ok, "R2 word write ready", 32'(wr_word_ready), 32'(exp_ok));
    if (wr_word_ready)
      for (int k = 0; k < LANES; k++) lane_q[k].push_back(d[k*8 +: 8]);
    @(posedge clk); #0.5;
    wr_word_valid = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit exp_ok);
    @(negedge clk);
    wr_byte_valid = 1'b1; wr_byte_data = d;
    #1;
    check(wr_byte_ready == exp_ok, "R3 byte write ready", 32'(wr_byte_ready), 32'(exp_ok));
    if (wr_byte_ready) lane_q[0].push_back(d);
    @(posedge clk); #0.5;
    wr_byte_valid = 1'b0;
  endtask

  task automatic take_word_model(input string t);
    logic [31:0] e;
    for (int k = 0; k < LANES; k++) e[k*8 +: 8] = lane_q[k].pop_front();
    exp_q.push_back(e); obs_q.push_back(rd_word_data); tag_q.push_back(t);
  endtask

  task automatic get_word(input bit exp_ok);
    @(negedge clk);
    rd_word_ready = 1'b1;
    #1;
    check(rd_word_valid == exp_ok, "R4 word read valid", 32'(rd_word_valid), 32'(exp_ok));
    if (rd_word_valid) take_word_model("R4 word read data");
    @(posedge clk); #0.5;
    rd_word_ready = 1'b0;
  endtask

  task automatic get_byte(input bit exp_ok);
    @(negedge clk);
    rd_byte_ready = 1'b1;
    #1;
    check(rd_byte_valid == exp_ok, "R5 byte read valid", 32'(rd_byte_valid), 32'(exp_ok));
    if (rd_byte_valid) begin
      exp_q.push_back(32'(lane_q[0].pop_front()));
      obs_q.push_back(32'(rd_byte_data));
      tag_q.push_back("R5 byte read data");
    end
    @(posedge clk); #0.5;
    rd_byte_ready = 1'b0;
  endtask

  // R7: word push and word pop in one cycle.
  task automatic word_both(input logic [31:0] d);
    @(negedge clk);
    wr_word_valid = 1'b1; wr_word_data = d; rd_word_ready = 1'b1;
    #1;
    check(wr_word_ready && rd_word_valid, "R7 concurrent push/pop",
          {30'd0, wr_word_ready, rd_word_valid}, 32'd3);
    take_word_model("R7 concurrent read data");
    for (int k = 0; k < LANES; k++) lane_q[k].push_back(d[k*8 +: 8]);
    @(posedge clk); #0.5;
    wr_word_valid = 1'b0; rd_word_ready = 1'b0;
  endtask

  task automatic clear(input logic [5:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    check(flags == 6'h00, "R1 flags in reset", 32'(flags), 32'h0);
    check(wr_word_ready && wr_byte_ready, "R1 write ready in reset", {30'd0, wr_word_ready, wr_byte_ready}, 32'd3);
    check(!rd_word_valid && !rd_byte_valid, "R1 read valid in reset", {30'd0, rd_word_valid, rd_byte_valid}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    check(flags == 6'h04, "R8 empty flag after reset", 32'(flags), 32'h04);

    // R10: read from empty is illegal
    get_word(1'b0);
    idle(2);
    check(flags == 6'h24, "R10 illegal read sets error", 32'(flags), 32'h24);
    clear(6'h24);
    idle(1);
    check(flags == 6'h04, "R9 clear drops error, empty held", 32'(flags), 32'h04);

    // R2 / R6: fill with words
    for (int i = 0; i < DEPTH; i++) put_word(32'hA0B0C0D0 + 32'(i) * 32'h01010101, 1'b1);
    put_word(32'hDEADBEEF, 1'b0);
    #1;
    check(!wr_byte_ready, "R6 byte write blocked when lane 0 full", 32'(wr_byte_ready), 32'h0);
    idle(2);
    check(flags == 6'h3F, "R8 flags when full", 32'(flags), 32'h3F);
    clear(6'h3F);
    idle(1);
    check(flags == 6'h1B, "R9 clear re-asserts held conditions", 32'(flags), 32'h1B);

    // R7: concurrent push and pop
    get_word(1'b1);
    word_both(32'h13579BDF);
    #1;
    check(wr_word_ready, "R7 occupancy unchanged", 32'(wr_word_ready), 32'h1);
    for (int i = 0; i < DEPTH - 1; i++) get_word(1'b1);
    #1;
    check(!rd_word_valid, "R4 word valid drops when drained", 32'(rd_word_valid), 32'h0);

    // R4 / R5: byte path and mixed lanes
    put_byte(8'h11, 1'b1);
    #1;
    check(!rd_word_valid && rd_byte_valid, "R4 word needs every lane",
          {30'd0, rd_word_valid, rd_byte_valid}, 32'd1);
    clear(6'h3F);
    idle(1);
    check(flags == 6'h10, "R8 byte-only flags", 32'(flags), 32'h10);
    put_word(32'h77665544, 1'b1);
    get_word(1'b1);
    get_byte(1'b1);

    // R6 / R8: byte capacity and half flag
    for (int i = 0; i < DEPTH / 2 - 1; i++) put_byte(8'(8'h20 + i), 1'b1);
    clear(6'h3F);
    idle(1);
    check(flags == 6'h10, "R8 half flag clear below half", 32'(flags), 32'h10);
    put_byte(8'h2F, 1'b1);
    idle(2);
    check(flags == 6'h12, "R8 half flag at half", 32'(flags), 32'h12);
    for (int i = DEPTH / 2; i < DEPTH; i++) put_byte(8'(8'h40 + i), 1'b1);
    put_byte(8'hEE, 1'b0);
    #1;
    check(!wr_word_ready, "R6 word write blocked by full lane 0", 32'(wr_word_ready), 32'h0);
    for (int i = 0; i < DEPTH; i++) get_byte(1'b1);

    // R3: word write wins over byte write
    @(negedge clk);
    wr_word_valid = 1'b1; wr_word_data = 32'hCAFEF00D;
    wr_byte_valid = 1'b1; wr_byte_data = 8'h99;
    #1;
    check(wr_word_ready && !wr_byte_ready, "R3 word write priority",
          {30'd0, wr_word_ready, wr_byte_ready}, 32'd2);
    for (int k = 0; k < LANES; k++) lane_q[k].push_back(wr_word_data[k*8 +: 8]);
    @(posedge clk); #0.5;
    wr_word_valid = 1'b0; wr_byte_valid = 1'b0;

    // R5: word read wins over byte read
    @(negedge clk);
    rd_word_ready = 1'b1; rd_byte_ready = 1'b1;
    #1;
    check(rd_word_valid && !rd_byte_valid, "R5 word read priority",
          {30'd0, rd_word_valid, rd_byte_valid}, 32'd2);
    take_word_model("R5 word read under priority");
    @(posedge clk); #0.5;
    rd_word_ready = 1'b0; rd_byte_ready = 1'b0;

    idle(3);
    check(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule